// File: doc/BRIEF.md
# Boot Sector Write Protection Gate

This block sits between a flash command engine and the storage array. It decides for every program and erase action whether the action may touch the addressed word. It also applies the write rules of flash storage. Erasing sets words to all ones. Programming can only pull bits from one to zero, so the stored word becomes the old word ANDed with the new data. The command engine decodes the bus sequences and hands the block single-cycle strobes: program, erase and lock. The block does the rest in the cycle the strobe is sampled.

One fixed boot sector can be protected by a lock bit. The sector is the lowest or the highest 2^SECTOR_W words of a 2^ADDR_W word space, and a build-time parameter picks which. The defaults scale the space down so the array stays small. A 1 MB space with a 16 KB sector corresponds to ADDR_W=20 and SECTOR_W=14. The lock can be set but never cleared by a command; only the power-on reset clears it. An override input suspends the lock while it is held. The lock state can be read back through the data port in identification mode.

Top module: `bootSectorGate`

## Requirements
- R1: After reset every word reads 0xFF, the lock status reads 0 and `rejected` is low.
- R2: A program strobe stores old AND `wrData` at `addr`, visible on `rdData` from the next cycle; no bit ever goes from 0 to 1 by programming.
- R3: A lock strobe sets the lock. Only `rstN` clears it; no later command, erase or override clears it.
- R4: With `idMode` high and `addr` equal to 2, `rdData` returns the lock on bit 0 (1 = locked) and zeros above. Every other address in identification mode, and address 2 with `idMode` low, reads the array.
- R5: A program into the boot sector while locked with `override` low leaves the array unchanged. `rejected` is then high in exactly the cycle after the strobe.
- R6: Programs outside the boot sector proceed whatever the lock state is.
- R7: An erase sets every word outside the boot sector to 0xFF. It also sets the sector to 0xFF unless the lock is set and `override` is low; in that case the sector is left unchanged.
- R8: While `override` is high, sector programs and erases proceed and nothing is rejected. The lock takes effect again as soon as `override` falls.
- R9: With TOP_BOOT=0 the sector is words 0 to 2^SECTOR_W-1 (0..15 by default), and word 2^SECTOR_W is outside it. With TOP_BOOT=1 it is the top 2^SECTOR_W words.
- R10: When strobes coincide, erase wins over program and program wins over lock. The losing strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset; fills the array with ones and clears the lock |
| cmdProg | input | 1 | Program strobe for `addr` / `wrData` |
| cmdErase | input | 1 | Whole-array erase strobe |
| cmdLock | input | 1 | Lock-set strobe |
| override | input | 1 | Suspends the lock while high |
| idMode | input | 1 | Identification mode; maps the lock status to address 2 |
| addr | input | ADDR_W | Word address |
| wrData | input | DATA_W | Program data |
| rdData | output | DATA_W | Read data (array word or lock status) |
| rejected | output | 1 | One-cycle flag for a refused program |

## Verification
The hardest state to reach is an erase while locked on an array whose sector already holds programmed data. That data must be written before the lock is set, or under override, because a locked sector cannot otherwise be programmed. The stimulus therefore programs sector words first, sets the lock, and probes the exact sector boundary words. It then toggles override around programs and erases. A seeded random phase biases addresses toward the sector and mixes override changes and rare erases. A bench model of the array and the lock predicts every read.

// File: rtl/bootGatePkg.sv
package bootGatePkg;

  typedef struct packed {
    logic doProg;      // perform a program at addr
    logic doErase;     // perform a whole-array erase
    logic keepSector;  // erase must spare the boot sector
    logic doLock;      // set the lock bit
    logic refuse;      // program refused by protection
  } gateStrobes_t;

  // True when word address a lies in the boot sector of the configured space.
  function automatic logic inBootSector(input logic [31:0] a, input int addrW,
                                        input int sectW, input bit topBoot);
    logic [31:0] hi;
    logic [31:0] lim;
    hi  = a >> sectW;
    lim = (32'd1 << (addrW - sectW)) - 32'd1;
    return topBoot ? (hi == lim) : (hi == 32'd0);
  endfunction

endpackage

// File: rtl/bootGateCtrl.sv
module bootGateCtrl
  import bootGatePkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SECTOR_W = 4,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdProg,
  input  logic              cmdErase,
  input  logic              cmdLock,
  input  logic              override,
  input  logic [ADDR_W-1:0] addr,
  output gateStrobes_t      strobes,
  output logic              lockBit,
  output logic              rejected
);

  logic inSector;
  logic guarded;

  assign inSector = inBootSector(32'(addr), ADDR_W, SECTOR_W, TOP_BOOT);
  assign guarded  = lockBit && !override;

  always_comb begin
    strobes = '0;
    if (cmdErase) begin
      strobes.doErase    = 1'b1;
      strobes.keepSector = guarded;
    end else if (cmdProg) begin
      if (guarded && inSector) strobes.refuse = 1'b1;
      else                     strobes.doProg = 1'b1;
    end else if (cmdLock) begin
      strobes.doLock = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockBit  <= 1'b0;
      rejected <= 1'b0;
    end else begin
      lockBit  <= lockBit | strobes.doLock;
      rejected <= strobes.refuse;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockBit |=> lockBit); // R3

  AST_REJECT_NEEDS_PROG: assert property (@(posedge clk) disable iff (!rstN)
    rejected |-> ($past(cmdProg) && !$past(cmdErase))); // R5

  AST_OVERRIDE_NO_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    rejected |-> !$past(override)); // R8

  AST_REJECT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    rejected |-> $past(lockBit)); // R5

endmodule

// File: rtl/bootGateData.sv
module bootGateData
  import bootGatePkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SECTOR_W = 4,
  parameter int DATA_W   = 8,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              idMode,
  input  logic              lockBit,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SECTOR_WORDS = 1 << SECTOR_W;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] SEC_BASE = TOP_BOOT ? ADDR_W'(DEPTH - SECTOR_WORDS) : '0;
  localparam logic [ADDR_W-1:0] OUT_ADDR = TOP_BOOT ? '0 : ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  sectorMap;

  for (genvar i = 0; i < DEPTH; i++) begin : g_map
    localparam logic IN_SEC = inBootSector(32'(i), ADDR_W, SECTOR_W, TOP_BOOT);
    assign sectorMap[i] = IN_SEC;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strobes.doErase) begin
      for (int i = 0; i < DEPTH; i++)
        if (!(strobes.keepSector && sectorMap[i])) mem[i] <= '1;
    end else if (strobes.doProg) begin
      mem[addr] <= mem[addr] & wrData;
    end
  end

  assign rdData = (idMode && addr == STATUS_ADDR) ? DATA_W'(lockBit) : mem[addr];

  AST_PROG_AND: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doProg |=> mem[$past(addr)] == ($past(mem[addr]) & $past(wrData))); // R2

  AST_REFUSE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.refuse |=> mem[$past(addr)] == $past(mem[addr])); // R5

  AST_ERASE_KEEPS_SECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doErase && strobes.keepSector) |=> mem[SEC_BASE] == $past(mem[SEC_BASE])); // R7

  AST_ERASE_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doErase |=> mem[OUT_ADDR] == '1); // R7

  AST_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doLock |=> mem[$past(addr)] == $past(mem[addr])); // R10

endmodule

// File: rtl/bootSectorGate.sv
module bootSectorGate
  import bootGatePkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SECTOR_W = 4,
  parameter int DATA_W   = 8,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdProg,
  input  logic              cmdErase,
  input  logic              cmdLock,
  input  logic              override,
  input  logic              idMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rejected
);

  gateStrobes_t strobes;
  logic         lockBit;

  bootGateCtrl #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .TOP_BOOT(TOP_BOOT)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdProg(cmdProg), .cmdErase(cmdErase),
    .cmdLock(cmdLock), .override(override), .addr(addr),
    .strobes(strobes), .lockBit(lockBit), .rejected(rejected)
  );

  bootGateData #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .DATA_W(DATA_W),
                 .TOP_BOOT(TOP_BOOT)) i_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr), .wrData(wrData),
    .idMode(idMode), .lockBit(lockBit), .rdData(rdData)
  );

endmodule

// File: tb/test_bootSectorGate.sv
module test_bootSectorGate;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int SECTOR_W = 4;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SEC_WORDS = 1 << SECTOR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdProg = 1'b0, cmdErase = 1'b0, cmdLock = 1'b0;
  logic override = 1'b0, idMode = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic rejected;

  int checks = 0;
  int fails = 0;
  logic [7:0] expMem [DEPTH];
  logic expLock = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bootSectorGate i_bootSectorGate (
    .clk(clk), .rstN(rstN), .cmdProg(cmdProg), .cmdErase(cmdErase),
    .cmdLock(cmdLock), .override(override), .idMode(idMode), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rejected(rejected)
  );

  function automatic bit inSec(input int a);
    return a < SEC_WORDS;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic checkRead(input string req, input int a);
    idMode = 1'b0;
    addr = ADDR_W'(a);
    #1;
    check(req, rdData, expMem[a], $sformatf("read word %0d", a));
  endtask

  task automatic checkStatus(input string req);
    idMode = 1'b1;
    addr = ADDR_W'(2);
    #1;
    check(req, rdData, {7'b0, expLock}, "lock status");
    idMode = 1'b0;
  endtask

  task automatic modelReset();
    for (int i = 0; i < DEPTH; i++) expMem[i] = 8'hFF;
    expLock = 1'b0;
  endtask

  // Drive one strobe set for one cycle, update the model, check rejected.
  task automatic apply(input string req, input bit p, input bit e, input bit l,
                       input int a, input logic [7:0] d);
    logic expRej;
    @(negedge clk);
    cmdProg = p; cmdErase = e; cmdLock = l;
    addr = ADDR_W'(a); wrData = d; idMode = 1'b0;
    expRej = p && !e && expLock && !override && inSec(a);
    if (e) begin
      for (int i = 0; i < DEPTH; i++)
        if (!(expLock && !override && inSec(i))) expMem[i] = 8'hFF;
    end else if (p) begin
      if (!expRej) expMem[a] = expMem[a] & d;
    end else if (l) begin
      expLock = 1'b1;
    end
    @(negedge clk);
    cmdProg = 1'b0; cmdErase = 1'b0; cmdLock = 1'b0;
    #1;
    check(req, {7'b0, rejected}, {7'b0, expRej}, "rejected flag");
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    doReset();

    // R1 reset state
    checkRead("R1", 0);
    checkRead("R1", DEPTH - 1);
    checkStatus("R1");
    #1 check("R1", {7'b0, rejected}, 8'h00, "rejected after reset");

    // R2 program semantics
    apply("R2", 1, 0, 0, 5, 8'h0F);
    checkRead("R2", 5);
    apply("R2", 1, 0, 0, 5, 8'hF3);
    checkRead("R2", 5);
    apply("R2", 1, 0, 0, 300, 8'hA5);
    checkRead("R2", 300);

    // R4 identification mode mapping
    checkStatus("R4");
    idMode = 1'b1; addr = ADDR_W'(5); #1;
    check("R4", rdData, expMem[5], "id mode other address");
    checkRead("R4", 2);

    // R10 priority
    apply("R10", 1, 0, 1, 8, 8'h00);
    checkRead("R10", 8);
    checkStatus("R10");
    apply("R10", 1, 1, 0, 300, 8'h00);
    checkRead("R10", 300);
    checkRead("R10", 5);

    // R3 lock
    apply("R2", 1, 0, 0, 5, 8'h03);
    apply("R3", 0, 0, 1, 0, 8'h00);
    checkStatus("R3");

    // R5 refused program in sector, R9 boundaries, R6 outside
    apply("R5", 1, 0, 0, 7, 8'h00);
    checkRead("R5", 7);
    apply("R9", 1, 0, 0, SEC_WORDS - 1, 8'h00);
    checkRead("R9", SEC_WORDS - 1);
    apply("R9", 1, 0, 0, SEC_WORDS, 8'h12);
    checkRead("R9", SEC_WORDS);
    apply("R6", 1, 0, 0, DEPTH - 1, 8'h34);
    checkRead("R6", DEPTH - 1);

    // R8 override
    override = 1'b1;
    apply("R8", 1, 0, 0, 7, 8'h5A);
    checkRead("R8", 7);
    override = 1'b0;
    apply("R8", 1, 0, 0, 7, 8'h00);
    checkRead("R8", 7);

    // R7 erase while locked keeps the sector
    apply("R7", 0, 1, 0, 0, 8'h00);
    checkRead("R7", 5);
    checkRead("R7", 7);
    checkRead("R7", SEC_WORDS);
    checkRead("R7", DEPTH - 1);

    // R8 erase under override clears the sector; R3 lock survives
    override = 1'b1;
    apply("R8", 0, 1, 0, 0, 8'h00);
    override = 1'b0;
    checkRead("R8", 5);
    checkRead("R8", 7);
    checkStatus("R3");
    apply("R3", 0, 0, 1, 0, 8'h00);
    checkStatus("R3");

    // Random phase, biased toward the sector
    doReset();
    for (int n = 0; n < 600; n++) begin
      int r;
      int a;
      r = int'($urandom % 100);
      a = ($urandom % 2 == 1) ? int'($urandom % (2 * SEC_WORDS)) : int'($urandom % DEPTH);
      if ($urandom % 10 == 0) override = ~override;
      if (r < 80)      apply("R2", 1, 0, 0, a, 8'($urandom));
      else if (r < 84) apply("R7", 0, 1, 0, a, 8'($urandom));
      else if (r < 88) apply("R3", 0, 0, 1, a, 8'($urandom));
      else if (r < 92) apply("R10", 1'($urandom), 1'($urandom), 1'($urandom), a, 8'($urandom));
      else             checkStatus("R4");
      checkRead("R5", a);
      checkRead("R7", int'($urandom % SEC_WORDS));
    end
    override = 1'b0;

    // R3 only reset clears the lock
    apply("R3", 0, 0, 1, 0, 8'h00);
    doReset();
    checkStatus("R3");
    checkRead("R1", 5);

    summary();
    $finish;
  end

endmodule